// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time clock core. A slow tick enable, nominally 32768 Hz, is divided down to one pulse per second. Each pulse advances a packed-BCD calendar of seconds, minutes, hours, day, month and two-digit year (00 to 99, standing for 2000 to 2099). The calendar applies Gregorian month lengths, including leap Februaries. An alarm register set of the same six fields is compared against the calendar at every second update. Only an exact match on all six fields counts.

Software reaches the block over a byte-wide register port with address, write enable, write data and combinational read data. It starts and stops the clock through a control register. Sticky event flags for second, minute, hour, day and alarm are cleared by writing ones. Two interrupt lines follow the enabled flags. A busy flag marks the last tick period before each update, so software can avoid touching the time while it is about to change.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00. The control register (0x40) and status register (0x44) read 0x00, and both interrupt outputs are low.
- R2: The seconds field advances by one only when control bit 0 is 1 and TICKS_PER_SEC tick enables have been counted. Cycles with tick_en low are not counted, and a stopped clock never advances.
- R3: Seconds 0x59 roll to 0x00 and carry into minutes. Minutes 0x59 roll to 0x00 and carry into hours. Hours 0x23 roll to 0x00 and carry into the day.
- R4: A day rolls to 0x01 after the last day of its month and carries into the month. Months 4, 6, 9 and 11 have 30 days; the other months except February have 31. February has 29 days when the binary year value is divisible by 4, and 28 otherwise. Month 0x12 rolls to 0x01 and carries into the year, and year 0x99 rolls to 0x00.
- R5: Status bit 0 (busy) is 1 exactly while the clock runs and the prescaler is in the final tick period before an update. Status bit 1 mirrors control bit 0.
- R6: Status bits 2, 3, 4 and 5 are set by the second, minute, hour and day updates respectively. They hold until a 1 is written to that bit of 0x44.
- R7: Status bit 6 (alarm) is set on the update whose resulting time equals all six alarm fields (0x20 seconds to 0x34 year, one word apart). A difference in any single field prevents it.
- R8: When a clearing write and a new setting event fall in the same cycle, the bit ends up set. Writing 0 to a status bit leaves it unchanged.
- R9: A write to a time field (0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month, 0x14 year) loads it directly. A write to seconds also restarts the prescaler, so the next update follows after a full TICKS_PER_SEC ticks.
- R10: A time-field write in the same cycle as an update wins for that field, while every other field takes its rolled value.
- R11: irq_timer is high while interrupt-enable bit 2 (0x48) and status bit 2 are both 1. irq_alarm is high while interrupt-enable bit 3 and status bit 6 are both 1.
- R12: The alarm fields read back what was written. Only bit 0 of the control register and bits 2 and 3 of the interrupt-enable register are stored; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle tick enable at the oscillator rate |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_timer | output | 1 | Periodic second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
Two functions collide in the same clock edge: a one-second update that sets status flags while software clears them, and a second update while software writes a time field. The bench runs the clock for exactly four ticks and schedules the write to land on the update edge. It then reads status and requires the freshly set alarm and second flags to survive the clear. In the second case it requires the written minutes to replace the rolled value, while seconds still wrap to 0x00 and hours stay put.

// File: rtl/rtc_pkg.sv
// Shared types, register addresses and BCD helpers for the calendar clock.
// Assumes every BCD byte holds valid digits; no correction is attempted.
package rtc_pkg;

    localparam int NFIELD = 6;
    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 1;
    localparam int IDX_HOUR = 2;
    localparam int IDX_DAY  = 3;
    localparam int IDX_MON  = 4;
    localparam int IDX_YEAR = 5;

    // Six BCD bytes, index 0 = seconds ... index 5 = year
    typedef logic [NFIELD-1:0][7:0] cal_t;

    localparam logic [7:0] TIME_BASE  = 8'h00;
    localparam logic [7:0] ALARM_BASE = 8'h20;
    localparam logic [7:0] ADDR_CTRL  = 8'h40;
    localparam logic [7:0] ADDR_STAT  = 8'h44;
    localparam logic [7:0] ADDR_IEN   = 8'h48;

    // Increment a two-digit BCD value (caller handles the wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Convert two BCD digits to binary
    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
    endfunction

    // Last valid day of a month, in BCD
    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = bcd_to_bin(yr);
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the tick enable into one update pulse per TICKS_PER_SEC ticks.
// Assumes TICKS_PER_SEC >= 2. busy marks the final tick period before a pulse.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick_en,
    input  logic restart,
    output logic sec_pulse,
    output logic busy
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last   = (cnt_q == LAST);
    assign sec_pulse = run && tick_en && at_last;
    assign busy      = run && at_last;

    // Sub-second counter: cleared on restart, counts ticks while running
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (restart)          cnt_q <= '0;
        else if (run && tick_en)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/rtc_calendar.sv
// Holds the six BCD time fields and computes their next value.
// On step the fields roll with carries; a field write overrides its rolled value.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [NFIELD-1:0] wr_sel,
    input  logic [7:0]        wr_data,
    output cal_t              cur,
    output cal_t              nxt,
    output logic              carry_min,
    output logic              carry_hour,
    output logic              carry_day
);
    localparam cal_t RESET_CAL = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    cal_t rolled;
    logic carry_mon;
    logic carry_year;

    // Rollover chain from seconds up to year
    always_comb begin
        rolled     = cur;
        carry_min  = 1'b0;
        carry_hour = 1'b0;
        carry_day  = 1'b0;
        carry_mon  = 1'b0;
        carry_year = 1'b0;
        if (step) begin
            if (cur[IDX_SEC] == 8'h59) begin
                rolled[IDX_SEC] = 8'h00;
                carry_min       = 1'b1;
            end else begin
                rolled[IDX_SEC] = bcd_inc(cur[IDX_SEC]);
            end
            if (carry_min) begin
                if (cur[IDX_MIN] == 8'h59) begin
                    rolled[IDX_MIN] = 8'h00;
                    carry_hour      = 1'b1;
                end else begin
                    rolled[IDX_MIN] = bcd_inc(cur[IDX_MIN]);
                end
            end
            if (carry_hour) begin
                if (cur[IDX_HOUR] == 8'h23) begin
                    rolled[IDX_HOUR] = 8'h00;
                    carry_day        = 1'b1;
                end else begin
                    rolled[IDX_HOUR] = bcd_inc(cur[IDX_HOUR]);
                end
            end
            if (carry_day) begin
                if (cur[IDX_DAY] == month_len(cur[IDX_MON], cur[IDX_YEAR])) begin
                    rolled[IDX_DAY] = 8'h01;
                    carry_mon       = 1'b1;
                end else begin
                    rolled[IDX_DAY] = bcd_inc(cur[IDX_DAY]);
                end
            end
            if (carry_mon) begin
                if (cur[IDX_MON] == 8'h12) begin
                    rolled[IDX_MON] = 8'h01;
                    carry_year      = 1'b1;
                end else begin
                    rolled[IDX_MON] = bcd_inc(cur[IDX_MON]);
                end
            end
            if (carry_year) begin
                rolled[IDX_YEAR] = (cur[IDX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur[IDX_YEAR]);
            end
        end
    end

    // Per-field write override
    for (genvar i = 0; i < NFIELD; i++) begin : g_nxt
        assign nxt[i] = wr_sel[i] ? wr_data : rolled[i];
    end

    // Time register bank
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= RESET_CAL;
        else        cur <= nxt;
    end

endmodule

// File: rtl/rtc_alarm.sv
// Stores the alarm fields and flags an exact match of all six against a candidate time.
// There are no per-field masks; every field must be equal.
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFIELD-1:0] wr_sel,
    input  logic [7:0]        wr_data,
    input  cal_t              cand,
    output cal_t              alarm,
    output logic              hit
);
    logic [NFIELD-1:0] eq;

    // Field-wise compare
    for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
        assign eq[i] = (cand[i] == alarm[i]);
    end
    assign hit = &eq;

    // Alarm register bank, one byte per field
    for (genvar i = 0; i < NFIELD; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)         alarm[i] <= 8'h00;
            else if (wr_sel[i]) alarm[i] <= wr_data;
        end
    end

endmodule

// File: rtl/bcd_rtc_core.sv
// Calendar clock top: register decode, control, sticky status and interrupts.
// Assumes a byte bus with combinational reads; status bits are write-one-to-clear,
// and a new event in the same cycle as a clear wins.
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [7:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_timer,
    output logic       irq_alarm
);
    localparam int NEVT = 4;

    logic [NFIELD-1:0] wr_time;
    logic [NFIELD-1:0] wr_alm;
    logic              wr_ctrl, wr_stat, wr_ien;
    logic              run_q;
    logic              ie_tmr_q, ie_alm_q;
    logic [NEVT-1:0]   evt_q;
    logic [NEVT-1:0]   evt_set;
    logic              alm_st_q;
    logic              sec_pulse, busy;
    logic              carry_min, carry_hour, carry_day;
    logic              hit;
    cal_t              cur, nxt, alarm;

    // Address decode for field writes
    for (genvar i = 0; i < NFIELD; i++) begin : g_dec
        assign wr_time[i] = bus_we && (bus_addr == TIME_BASE  + 8'(i * 4));
        assign wr_alm[i]  = bus_we && (bus_addr == ALARM_BASE + 8'(i * 4));
    end
    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_stat = bus_we && (bus_addr == ADDR_STAT);
    assign wr_ien  = bus_we && (bus_addr == ADDR_IEN);

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .tick_en   (tick_en),
        .restart   (wr_time[IDX_SEC]),
        .sec_pulse (sec_pulse),
        .busy      (busy)
    );

    rtc_calendar u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (sec_pulse),
        .wr_sel     (wr_time),
        .wr_data    (bus_wdata),
        .cur        (cur),
        .nxt        (nxt),
        .carry_min  (carry_min),
        .carry_hour (carry_hour),
        .carry_day  (carry_day)
    );

    rtc_alarm u_alm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_alm),
        .wr_data (bus_wdata),
        .cand    (nxt),
        .alarm   (alarm),
        .hit     (hit)
    );

    // Control and interrupt-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            ie_tmr_q <= 1'b0;
            ie_alm_q <= 1'b0;
        end else begin
            if (wr_ctrl) run_q <= bus_wdata[0];
            if (wr_ien) begin
                ie_tmr_q <= bus_wdata[2];
                ie_alm_q <= bus_wdata[3];
            end
        end
    end

    assign evt_set = {carry_day, carry_hour, carry_min, sec_pulse};

    // Sticky event flags, status bits 2..5; set has priority over clear
    for (genvar k = 0; k < NEVT; k++) begin : g_evt
        always_ff @(posedge clk) begin
            if (!rst_n) evt_q[k] <= 1'b0;
            else        evt_q[k] <= evt_set[k] | (evt_q[k] & ~(wr_stat & bus_wdata[k + 2]));
        end
    end

    // Sticky alarm flag, status bit 6
    always_ff @(posedge clk) begin
        if (!rst_n) alm_st_q <= 1'b0;
        else        alm_st_q <= (sec_pulse & hit) | (alm_st_q & ~(wr_stat & bus_wdata[6]));
    end

    assign irq_timer = ie_tmr_q & evt_q[0];
    assign irq_alarm = ie_alm_q & alm_st_q;

    // Read multiplexer
    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 0; i < NFIELD; i++) begin
            if (bus_addr == TIME_BASE  + 8'(i * 4)) bus_rdata = cur[i];
            if (bus_addr == ALARM_BASE + 8'(i * 4)) bus_rdata = alarm[i];
        end
        if (bus_addr == ADDR_CTRL) bus_rdata = {7'b0, run_q};
        if (bus_addr == ADDR_STAT) bus_rdata = {1'b0, alm_st_q, evt_q, run_q, busy};
        if (bus_addr == ADDR_IEN)  bus_rdata = {4'b0, ie_alm_q, ie_tmr_q, 2'b0};
    end

endmodule

// File: rtl/rtc_core_checker.sv
// Temporal checks on the calendar clock, bound to the top module.
module rtc_core_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       run,
    input logic       busy,
    input logic       sec_pulse,
    input logic       sec_wr,
    input logic [7:0] sec_val,
    input logic       evt_sec,
    input logic       alarm_st
);
    // R2
    pulse_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (run && tick_en));

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !sec_wr && sec_val == 8'h59) |=> (sec_val == 8'h00));

    // R5
    busy_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run);

    // R6
    sec_event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> evt_sec);

    // R7
    alarm_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_st) |-> $past(sec_pulse));

    // R9
    restart_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> !busy);
endmodule

bind bcd_rtc_core rtc_core_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .run       (run_q),
    .busy      (busy),
    .sec_pulse (sec_pulse),
    .sec_wr    (wr_time[0]),
    .sec_val   (cur[0]),
    .evt_sec   (evt_q[0]),
    .alarm_st  (alm_st_q)
);

// File: tb/bcd_rtc_core_test.sv
`timescale 1ns/1ps
module bcd_rtc_core_test;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_timer, irq_alarm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard queues: 0 = register read, 1 = irq_timer, 2 = irq_alarm
    int         q_kind[$];
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #2.5 clk = ~clk;

    bcd_rtc_core #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_timer(irq_timer), .irq_alarm(irq_alarm)
    );

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic chk_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(tag);
    endtask

    task automatic chk_pin(input int kind, input logic e, input string tag);
        @(negedge clk);
        bus_we = 1'b0;
        q_kind.push_back(kind); q_exp.push_back({7'b0, e}); q_tag.push_back(tag);
    endtask

    task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
        wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
    endtask

    task automatic set_alarm(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                             input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        wr(8'h34, y); wr(8'h30, mo); wr(8'h2C, d);
        wr(8'h28, h); wr(8'h24, mi); wr(8'h20, s);
    endtask

    // Run exactly one update: start at E0, stop at E4 where the pulse occurs
    task automatic one_second();
        wr(8'h40, 8'h01);
        repeat (3) @(negedge clk);
        wr(8'h40, 8'h00);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Monitor: compares queued expectations just after the driving negedge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_kind.size() > 0) begin
                int k;
                logic [7:0] e, act;
                string t;
                k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
                act = (k == 0) ? bus_rdata : (k == 1) ? {7'b0, irq_timer} : {7'b0, irq_alarm};
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, act, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_reg(8'h00, 8'h00, "R1 sec");
        chk_reg(8'h04, 8'h00, "R1 min");
        chk_reg(8'h08, 8'h00, "R1 hour");
        chk_reg(8'h0C, 8'h01, "R1 day");
        chk_reg(8'h10, 8'h01, "R1 month");
        chk_reg(8'h14, 8'h00, "R1 year");
        chk_reg(8'h40, 8'h00, "R1 ctrl");
        chk_reg(8'h44, 8'h00, "R1 status");
        chk_pin(1, 1'b0, "R1 irq_timer");
        chk_pin(2, 1'b0, "R1 irq_alarm");

        // R12 register readback
        set_alarm(8'h07, 8'h06, 8'h05, 8'h08, 8'h09, 8'h10);
        chk_reg(8'h20, 8'h10, "R12 alarm sec");
        chk_reg(8'h2C, 8'h05, "R12 alarm day");
        chk_reg(8'h34, 8'h07, "R12 alarm year");
        wr(8'h40, 8'h08);
        chk_reg(8'h40, 8'h00, "R12 ctrl unused bit");
        wr(8'h48, 8'hFF);
        chk_reg(8'h48, 8'h0C, "R12 ien");
        wr(8'h48, 8'h00);

        // R9 / R5 / R6: seconds write restarts the prescaler, busy before the update
        wr(8'h00, 8'h10);
        wr(8'h44, 8'h7C);
        wr(8'h40, 8'h01);
        chk_reg(8'h44, 8'h02, "R5 run shown");
        chk_reg(8'h00, 8'h10, "R9 sec loaded");
        chk_reg(8'h44, 8'h02, "R5 not busy");
        chk_reg(8'h44, 8'h03, "R5 busy window");
        chk_reg(8'h00, 8'h11, "R2 sec advanced");
        chk_reg(8'h44, 8'h06, "R6 sec event");
        wr(8'h40, 8'h00);
        repeat (12) @(negedge clk);
        chk_reg(8'h00, 8'h11, "R2 stopped");
        tick_en = 1'b0;
        wr(8'h40, 8'h01);
        repeat (12) @(negedge clk);
        chk_reg(8'h00, 8'h11, "R2 no ticks");
        wr(8'h40, 8'h00);
        tick_en = 1'b1;

        // R3 / R4 full rollover
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        wr(8'h44, 8'h7C);
        one_second();
        chk_reg(8'h00, 8'h00, "R3 sec wrap");
        chk_reg(8'h04, 8'h00, "R3 min wrap");
        chk_reg(8'h08, 8'h00, "R3 hour wrap");
        chk_reg(8'h0C, 8'h01, "R4 day wrap");
        chk_reg(8'h10, 8'h01, "R4 month wrap");
        chk_reg(8'h14, 8'h00, "R4 year wrap");
        chk_reg(8'h44, 8'h3C, "R6 all events");

        // R4 leap February
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        one_second();
        chk_reg(8'h0C, 8'h29, "R4 leap day 29");
        chk_reg(8'h10, 8'h02, "R4 leap month");
        set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
        one_second();
        chk_reg(8'h0C, 8'h01, "R4 leap end day");
        chk_reg(8'h10, 8'h03, "R4 leap end month");
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        one_second();
        chk_reg(8'h0C, 8'h01, "R4 common Feb day");
        chk_reg(8'h10, 8'h03, "R4 common Feb month");
        set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        one_second();
        chk_reg(8'h0C, 8'h01, "R4 30-day day");
        chk_reg(8'h10, 8'h05, "R4 30-day month");

        // R3 minute carry only
        set_time(8'h23, 8'h04, 8'h10, 8'h12, 8'h34, 8'h59);
        wr(8'h44, 8'h7C);
        one_second();
        chk_reg(8'h04, 8'h35, "R3 min carry");
        chk_reg(8'h08, 8'h12, "R3 hour held");
        chk_reg(8'h44, 8'h0C, "R6 min+sec events");

        // R7 / R11 alarm hit
        wr(8'h48, 8'h08);
        set_time(8'h07, 8'h06, 8'h05, 8'h08, 8'h09, 8'h09);
        wr(8'h44, 8'h7C);
        one_second();
        chk_reg(8'h44, 8'h44, "R7 alarm set");
        chk_pin(2, 1'b1, "R11 irq_alarm high");
        chk_pin(1, 1'b0, "R11 irq_timer masked");
        wr(8'h44, 8'h40);
        chk_reg(8'h44, 8'h04, "R6 alarm cleared");
        chk_pin(2, 1'b0, "R11 irq_alarm low");
        wr(8'h44, 8'h00);
        chk_reg(8'h44, 8'h04, "R8 zero write keeps");

        // R7 miss on year only
        set_time(8'h08, 8'h06, 8'h05, 8'h08, 8'h09, 8'h09);
        wr(8'h44, 8'h7C);
        one_second();
        chk_reg(8'h44, 8'h04, "R7 year mismatch");

        // R8 clear and set on the same edge
        set_time(8'h07, 8'h06, 8'h05, 8'h08, 8'h09, 8'h09);
        wr(8'h44, 8'h7C);
        wr(8'h40, 8'h01);
        repeat (3) @(negedge clk);
        wr(8'h44, 8'h7C);
        chk_reg(8'h44, 8'h46, "R8 set wins");
        wr(8'h40, 8'h00);

        // R10 write during update
        set_time(8'h23, 8'h04, 8'h10, 8'h12, 8'h34, 8'h59);
        wr(8'h40, 8'h01);
        repeat (3) @(negedge clk);
        wr(8'h04, 8'h50);
        wr(8'h40, 8'h00);
        chk_reg(8'h00, 8'h00, "R10 sec rolled");
        chk_reg(8'h04, 8'h50, "R10 min written");
        chk_reg(8'h08, 8'h12, "R10 hour held");

        // R11 timer interrupt
        wr(8'h48, 8'h04);
        chk_pin(1, 1'b1, "R11 irq_timer high");
        wr(8'h44, 8'h04);
        chk_pin(1, 1'b0, "R11 irq_timer low");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule